// File: doc/BRIEF.md
# Byte-Wide Master/Slave Serial Shifter

The block moves one byte at a time over a three-wire synchronous serial link made of a clock, a data output and a data input. A control input sets the role. In master role the block makes the serial clock itself by dividing the system clock, with four selectable rates. In slave role it follows a serial clock from outside, which it brings into the system clock domain before use. There is no select line of any kind, so the role comes only from the control input.

Whatever the role, outgoing bits change on falling serial clock edges and incoming bits are taken on rising edges. One control bit sets only the level at which the serial clock rests between transfers. When the clock rests low, each transfer has one extra leading rise, which samples nothing, and one extra trailing fall, which shifts nothing.

Software works the block through a small register-style port. It writes a transmit byte, pulses a start strobe, watches a completion flag and reads the received byte. A collision flag records any transmit write that arrives while a transfer is running.

Top module: `byte_serial_xfer`

## Requirements
- R1: Reset state. While and after reset, before any start: sck_o=1, sdo=0, busy=0, done=0, collision=0 and rx_data=0.
- R2: Resting level. When no transfer is running, sck_o is 1 if cfg_idle_low=0 and 0 if cfg_idle_low=1. The output follows a change of cfg_idle_low one clock later.
- R3: Master clock rate. With cfg_master=1, each serial clock half period lasts 2<<cfg_rate system clocks, so codes 0, 1, 2 and 3 give periods of 4, 8, 16 and 32 clocks. The first edge comes one half period after the start is taken. busy stays high for 16 half periods with cfg_idle_low=0, or 18 with cfg_idle_low=1 (one leading rise and one trailing fall added).
- R4: sdo changes only on a falling serial clock edge. Falling edge k of the transfer (k=1..8) drives bit 8-k of the byte that was held when the start was taken, so the MSB goes first. A falling edge after the eighth sampling rise leaves sdo unchanged.
- R5: sdi is sampled only on rising edges that follow the transfer's first falling edge, so a leading rise samples nothing. The first sampled bit becomes rx_data bit 7 and the last becomes bit 0.
- R6: The eighth sampling rise completes the transfer. done goes to 1 and rx_data takes the new byte at the same clock edge at which sck_o rises in master role.
- R7: With cfg_master=0, the edges of sck_in, after a two-stage synchronizer, control the shifting under the same rules as R4 to R6. sck_o stays at the resting level of R2.
- R8: done clears one clock after rd_rx=1 or after an accepted start. A completion in the same clock takes priority over rd_rx.
- R9: tx_wr while busy=1 leaves the held transmit byte unchanged and sets collision=1 one clock later. collision clears on the next accepted start. A start loads the byte held before that clock's write.
- R10: start is taken only while busy=0, and busy=1 from the next clock. A start while busy=1 has no effect on the running transfer or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_master | input | 1 | 1 = master role (makes the serial clock), 0 = slave role |
| cfg_idle_low | input | 1 | 0 = serial clock rests high, 1 = rests low |
| cfg_rate | input | RATE_W | Master clock divider select |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Transmit byte |
| start | input | 1 | Start strobe for one transfer |
| rd_rx | input | 1 | Read strobe; clears done |
| rx_data | output | DATA_W | Last received byte |
| busy | output | 1 | A transfer is running |
| done | output | 1 | A transfer has completed |
| collision | output | 1 | A transmit write came in while busy |
| sck_in | input | 1 | External serial clock (slave role) |
| sck_o | output | 1 | Generated serial clock (master role) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The properties assume that cfg_master, cfg_idle_low and cfg_rate change only while the block is idle, and they qualify their clock-level checks on these controls holding steady across the cycles they compare. The stimulus changes the controls only between transfers, and it lets a few clocks pass before the next start. In slave role it assumes the external clock holds each level for at least four system clocks and that sdi changes only on external falling edges. The bench's external master uses six-clock half periods and drives sdi only when it lowers sck_in.

// File: rtl/sx_pkg.sv
package sx_pkg;
  // One-cycle strobes marking serial clock transitions in the system domain
  typedef struct packed {
    logic rise;
    logic fall;
  } sx_edge_t;
endpackage

// File: rtl/sx_sckgen.sv
module sx_sckgen
  import sx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              idle_low,
  input  logic [RATE_W-1:0] rate,
  output logic              sck,
  output logic              run,
  output sx_edge_t          ev
);
  localparam int CNT_W     = (1 << RATE_W) + 1;
  localparam int TOG_PLAIN = 2 * DATA_W;
  localparam int TOG_PRE   = 2 * DATA_W + 2;
  localparam int TOG_W     = $clog2(TOG_PRE + 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half_m1;
  logic [TOG_W-1:0]  tog;
  logic [TOG_W-1:0]  tog_last;
  logic [RATE_W-1:0] rate_q;
  logic              idle_q;
  logic              tick;

  always_comb begin
    half_m1  = (CNT_W'(2) << rate_q) - CNT_W'(1);
    tog_last = idle_q ? TOG_W'(TOG_PRE - 1) : TOG_W'(TOG_PLAIN - 1);
    tick     = run && (cnt == half_m1);
    ev.fall  = tick && sck;
    ev.rise  = tick && !sck;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      tog    <= '0;
      sck    <= 1'b1;
      rate_q <= '0;
      idle_q <= 1'b0;
    end else if (!run) begin
      sck <= !idle_low;
      if (start) begin
        run    <= 1'b1;
        cnt    <= '0;
        tog    <= '0;
        rate_q <= rate;
        idle_q <= idle_low;
      end
    end else if (tick) begin
      sck <= !sck;
      cnt <= '0;
      tog <= tog + 1'b1;
      if (tog == tog_last) run <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sx_sync.sv
module sx_sync
  import sx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     din,
  output sx_edge_t ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  always_comb begin
    ev.rise = chain[STAGES-1] && !prev;
    ev.fall = !chain[STAGES-1] && prev;
  end
endmodule

// File: rtl/sx_shifter.sv
module sx_shifter
  import sx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] load,
  input  sx_edge_t          ev,
  input  logic              sdi,
  output logic              sdo,
  output logic              active,
  output logic              complete,
  output logic [DATA_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  nrx;
  logic              seen;

  assign complete = active && ev.rise && seen && (nrx == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      sdo     <= 1'b0;
      active  <= 1'b0;
      seen    <= 1'b0;
      nrx     <= '0;
      rx_word <= '0;
    end else if (start) begin
      sh     <= load;
      active <= 1'b1;
      seen   <= 1'b0;
      nrx    <= '0;
    end else if (active) begin
      if (ev.fall) begin
        sdo  <= sh[DATA_W-1];
        sh   <= {sh[DATA_W-2:0], 1'b0};
        seen <= 1'b1;
      end else if (ev.rise && seen) begin
        sh[0] <= sdi;
        nrx   <= nrx + 1'b1;
        if (complete) begin
          active  <= 1'b0;
          rx_word <= {sh[DATA_W-1:1], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/byte_serial_xfer.sv
module byte_serial_xfer
  import sx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RATE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_idle_low,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic              rd_rx,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  output logic              collision,
  input  logic              sck_in,
  output logic              sck_o,
  input  logic              sdi,
  output logic              sdo
);
  logic              start_ok;
  logic              gen_run;
  logic              sh_act;
  logic              complete;
  logic [DATA_W-1:0] tx_hold;
  sx_edge_t          gen_ev;
  sx_edge_t          ext_ev;
  sx_edge_t          ev;

  assign busy     = gen_run | sh_act;
  assign start_ok = start & ~busy;
  assign ev       = cfg_master ? gen_ev : ext_ev;

  sx_sckgen #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .start    (start_ok & cfg_master),
    .idle_low (cfg_idle_low),
    .rate     (cfg_rate),
    .sck      (sck_o),
    .run      (gen_run),
    .ev       (gen_ev)
  );

  sx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (sck_in),
    .ev  (ext_ev)
  );

  sx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (start_ok),
    .load     (tx_hold),
    .ev       (ev),
    .sdi      (sdi),
    .sdo      (sdo),
    .active   (sh_act),
    .complete (complete),
    .rx_word  (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold   <= '0;
      done      <= 1'b0;
      collision <= 1'b0;
    end else begin
      if (tx_wr && !busy) tx_hold <= wr_data;

      if (complete)                done <= 1'b1;
      else if (start_ok || rd_rx)  done <= 1'b0;

      if (start_ok)               collision <= 1'b0;
      else if (tx_wr && busy)     collision <= 1'b1;
    end
  end
endmodule

// File: rtl/sx_checker.sv
module sx_checker (
  input logic clk,
  input logic rst,
  input logic cfg_master,
  input logic cfg_idle_low,
  input logic start,
  input logic tx_wr,
  input logic rd_rx,
  input logic sck_o,
  input logic sdo,
  input logic busy,
  input logic done,
  input logic collision
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(rst) && $stable(cfg_idle_low)) |-> (sck_o == !cfg_idle_low)); // R2

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $past(cfg_master) && !$past(rst) && (sdo != $past(sdo))) |-> $fell(sck_o)); // R4

  AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $past(cfg_master) && !$past(rst) && $rose(done)) |-> $rose(sck_o)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && !busy) |=> !done); // R8

  AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && busy) |=> collision); // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R10
endmodule

bind byte_serial_xfer sx_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_master   (cfg_master),
  .cfg_idle_low (cfg_idle_low),
  .start        (start),
  .tx_wr        (tx_wr),
  .rd_rx        (rd_rx),
  .sck_o        (sck_o),
  .sdo          (sdo),
  .busy         (busy),
  .done         (done),
  .collision    (collision)
);

// File: tb/byte_serial_xfer_tb.sv
module byte_serial_xfer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_master = 1'b1;
  logic       cfg_idle_low = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic       tx_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       start = 1'b0;
  logic       rd_rx = 1'b0;
  logic       sck_in = 1'b1;
  logic       sdi_drv = 1'b0;
  logic       loop = 1'b1;
  logic       sdi;
  logic [7:0] rx_data;
  logic       busy, done, collision, sck_o, sdo;

  assign sdi = loop ? sdo : sdi_drv;

  byte_serial_xfer u_dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_idle_low(cfg_idle_low),
    .cfg_rate(cfg_rate), .tx_wr(tx_wr), .wr_data(wr_data), .start(start),
    .rd_rx(rd_rx), .rx_data(rx_data), .busy(busy), .done(done),
    .collision(collision), .sck_in(sck_in), .sck_o(sck_o), .sdi(sdi), .sdo(sdo)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model of the master role, advanced on every clock
  int         cyc = 0;
  int         tq[$];
  bit         bq[$];
  bit         m_run, m_act, m_seen, m_sck = 1'b1, m_sdo, m_done, m_coll, mb, smp;
  logic [7:0] m_hold, m_rxv, m_rx;
  int         m_nrx, nt, h;
  bit         cmp_en = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_run = 0; m_act = 0; m_seen = 0; m_sck = 1; m_sdo = 0; m_done = 0;
      m_coll = 0; m_hold = 0; m_rx = 0; m_rxv = 0; m_nrx = 0;
      tq.delete(); bq.delete();
    end else begin
      mb  = m_run || m_act;
      smp = loop ? m_sdo : sdi_drv;
      if (tx_wr && mb) m_coll = 1;
      if (start && !mb) begin
        m_coll = 0; m_done = 0; m_act = 1; m_seen = 0; m_nrx = 0; m_rxv = 0;
        bq.delete();
        for (int b = 7; b >= 0; b--) bq.push_back(m_hold[b]);
        if (cfg_master) begin
          m_run = 1;
          nt = cfg_idle_low ? 18 : 16;
          h  = 2 << cfg_rate;
          tq.delete();
          for (int k = 1; k <= nt; k++) tq.push_back(cyc + k * h);
        end
      end else if (rd_rx) begin
        m_done = 0;
      end
      if (tx_wr && !mb) m_hold = wr_data;
      if (m_run && tq.size() > 0 && tq[0] == cyc) begin
        void'(tq.pop_front());
        m_sck = !m_sck;
        if (m_act) begin
          if (!m_sck) begin
            if (bq.size() > 0) m_sdo = bq.pop_front();
            m_seen = 1;
          end else if (m_seen) begin
            m_rxv = {m_rxv[6:0], smp};
            m_nrx++;
            if (m_nrx == 8) begin m_act = 0; m_done = 1; m_rx = m_rxv; end
          end
        end
        if (tq.size() == 0) m_run = 0;
      end else if (!m_run) begin
        m_sck = !cfg_idle_low;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check(sck_o === m_sck, "R3", "sck_o per clock", sck_o, m_sck);
      check(sdo === m_sdo, "R4", "sdo per clock", sdo, m_sdo);
      check(busy === (m_run || m_act), "R10", "busy per clock", busy, m_run || m_act);
      check(done === m_done, "R6", "done per clock", done, m_done);
      check(collision === m_coll, "R9", "collision per clock", collision, m_coll);
      check(rx_data === m_rx, "R5", "rx_data per clock", rx_data, m_rx);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog R10 actual=%0d expected=below %0d cycles", wd, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] v);
    tx_wr = 1; wr_data = v; @(negedge clk); tx_wr = 0;
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_idle(input int restart_at, output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      start = (n == restart_at);
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [1:0] rate,
                             input bit idle_low, input bit lb, input bit cval,
                             input logic [7:0] exp_rx, input int restart_at);
    int n;
    cfg_rate = rate; cfg_idle_low = idle_low; loop = lb; sdi_drv = cval;
    tick(3);
    write_tx(tx);
    pulse_start();
    wait_idle(restart_at, n);
    check(n == (idle_low ? 18 : 16) * (2 << rate), "R3", "busy length", n,
          (idle_low ? 18 : 16) * (2 << rate));
    check(rx_data === exp_rx, "R5", "received byte", rx_data, exp_rx);
    check(done === 1'b1, "R6", "done after transfer", done, 1);
  endtask

  task automatic ext_shift(input logic [7:0] eb, input bit idle_low, output logic [7:0] got);
    int hp = 6;
    if (idle_low) begin sck_in = 1; tick(hp); end
    for (int i = 7; i >= 0; i--) begin
      sck_in = 0; sdi_drv = eb[i]; tick(hp);
      sck_in = 1; got[i] = sdo;
      check(sck_o === !idle_low, "R7", "sck_o rests in slave role", sck_o, !idle_low);
      tick(hp);
    end
    if (idle_low) begin sck_in = 0; tick(hp); end
  endtask

  initial begin
    logic [7:0] got;
    int n;
    tick(3);
    check(sck_o === 1'b1 && sdo === 1'b0 && busy === 1'b0, "R1", "pins in reset",
          {sck_o, sdo, busy}, 3'b100);
    rst = 0;
    @(negedge clk);
    check(sck_o === 1'b1, "R1", "sck_o after reset", sck_o, 1);
    check(sdo === 1'b0, "R1", "sdo after reset", sdo, 0);
    check(busy === 1'b0 && done === 1'b0 && collision === 1'b0, "R1", "flags after reset",
          {busy, done, collision}, 0);
    check(rx_data === 8'h00, "R1", "rx_data after reset", rx_data, 0);
    cmp_en = 1;

    // R5 R4: loopback, resting high, fastest rate
    master_xfer(8'hA5, 2'd0, 1'b0, 1'b1, 1'b0, 8'hA5, -1);
    rd_rx = 1; @(negedge clk); rd_rx = 0;
    check(done === 1'b0, "R8", "done cleared by read", done, 0);

    // R5: resting low, the leading rise must not sample
    master_xfer(8'h3C, 2'd1, 1'b1, 1'b1, 1'b0, 8'h3C, -1);
    master_xfer(8'hC3, 2'd2, 1'b1, 1'b0, 1'b1, 8'hFF, -1);
    master_xfer(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00, -1);

    // R2: resting level follows the control while idle
    cfg_idle_low = 1; tick(2);
    check(sck_o === 1'b0, "R2", "rest low", sck_o, 0);
    cfg_idle_low = 0; tick(2);
    check(sck_o === 1'b1, "R2", "rest high", sck_o, 1);

    // R8: accepted start clears done
    loop = 1; cfg_rate = 2'd0;
    write_tx(8'h5A);
    check(done === 1'b1, "R8", "done kept by write", done, 1);
    pulse_start();
    check(done === 1'b0, "R8", "done cleared by start", done, 0);
    wait_idle(-1, n);
    check(rx_data === 8'h5A, "R5", "loopback 5A", rx_data, 8'h5A);

    // R9: write while busy is dropped and flagged
    cfg_rate = 2'd2;
    write_tx(8'h55);
    pulse_start();
    tick(10);
    write_tx(8'hFF);
    check(collision === 1'b1, "R9", "collision set", collision, 1);
    wait_idle(-1, n);
    pulse_start();
    check(collision === 1'b0, "R9", "collision cleared by start", collision, 0);
    wait_idle(-1, n);
    check(rx_data === 8'h55, "R9", "held byte kept", rx_data, 8'h55);

    // R10: start while busy has no effect on data or length
    master_xfer(8'h96, 2'd1, 1'b0, 1'b1, 1'b0, 8'h96, 7);
    master_xfer(8'h69, 2'd0, 1'b1, 1'b1, 1'b0, 8'h69, 20);

    // R7: slave role, resting high
    cmp_en = 0;
    tick(2);
    cfg_master = 0; loop = 0; cfg_idle_low = 0; sck_in = 1;
    tick(6);
    write_tx(8'h96);
    pulse_start();
    check(busy === 1'b1, "R7", "busy in slave role", busy, 1);
    ext_shift(8'h4B, 1'b0, got);
    tick(6);
    check(got === 8'h96, "R7", "slave sdo byte", got, 8'h96);
    check(rx_data === 8'h4B, "R7", "slave received byte", rx_data, 8'h4B);
    check(done === 1'b1 && busy === 1'b0, "R7", "slave completion", {done, busy}, 2'b10);

    // R7 R5: slave role, resting low with leading rise
    sck_in = 0; cfg_idle_low = 1;
    tick(6);
    write_tx(8'h2D);
    pulse_start();
    ext_shift(8'hD2, 1'b1, got);
    tick(6);
    check(got === 8'h2D, "R7", "slave sdo byte rest low", got, 8'h2D);
    check(rx_data === 8'hD2, "R7", "slave received byte rest low", rx_data, 8'hD2);
    check(sck_o === 1'b0, "R2", "sck_o rests low in slave role", sck_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule